// File: doc/BRIEF.md
# Audio-Frame Heartbeat Generator

This block gives a host controller a simple way to tell that the audio signal processor is alive. It counts audio frames, one per rising edge of the LR (word) clock, and flips an open-drain heartbeat pin each time a programmed number of frames has passed. The pin therefore shows a square wave whose low and high phases each last a fixed number of frames. With the preset count and a 48 kHz frame rate, each phase lasts about 85 ms.

The frame clock is the only time base. If the audio interface stops, the heartbeat stops too, and the host can read a frozen pin as a fault. The block pulses only while the processor reports normal operation through `run_en`. A design that waits for a start command after reset simply holds `run_en` low until that command arrives. A soft-reset pulse returns the block to its idle state. A test-request pulse flips the pin at once and starts a fresh phase. The frame count per phase can be reloaded for other sample rates, for example 3749 frames at 44.1 kHz or 2720 frames at 32 kHz.

Top module: `audio_wdog`

## Requirements
- R1: After reset the pin is released (`wdc_pull_low` = 0), the frame counter is zero and the period register holds its preset.
- R2: With `run_en` high, each rising edge of `lrclk_in` counts one frame, and falling edges count nothing. Every time the count reaches the period value, `wdc_pull_low` inverts and the count restarts. The first phase after the block is enabled is the released (high) phase.
- R3: The default period is 4080 frames. With no reload, the pin first pulls low after exactly 4080 rising edges.
- R4: A `period_load` pulse with a nonzero `period_value` writes the period register and restarts the phase count from zero. A load with value zero is ignored, and the period stays as it was.
- R5: While `run_en` is low, the counter is held at zero, the pin is released and LR clock edges have no effect.
- R6: A `soft_rst` pulse clears the counter and releases the pin on the next clock edge. It takes priority over every other input.
- R7: A `test_req` pulse while running and not in soft reset inverts the pin on the next clock edge and restarts the phase count. While `run_en` is low it has no effect.
- R8: If the LR clock holds steady and there is no test, soft reset or disable, the pin does not change.
- R9: A toggle caused by a frame edge shows at the pin no later than the third system clock edge after the LR clock rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lrclk_in | input | 1 | Audio LR clock, asynchronous to clk |
| run_en | input | 1 | Processor in normal operation |
| test_req | input | 1 | One-cycle test pulse: toggle now and restart the phase |
| soft_rst | input | 1 | One-cycle soft reset of the heartbeat |
| period_load | input | 1 | One-cycle strobe that writes the frames-per-phase value |
| period_value | input | CNT_W | New frames-per-phase value (zero is ignored) |
| wdc_pull_low | output | 1 | Open-drain enable: 1 pulls the pin low, 0 releases it |

## Verification
On every cycle the assertions check the effect of soft reset, disable and test pulses on the pin, the holding of the pin when no frame edge arrives, the period register's response to loads, and that the counter stays below the period. Only the bench's scenarios can show the frame-counting behaviour itself. This covers the exact number of rising edges per phase, including the 4080-frame default, the release-first phase order, the restart after a reload and the latency from the LR clock edge. The bench runs these against a frame-level model under random sequences of frames, loads, tests, soft resets and enable changes.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   // Action chosen for the current cycle, in priority order
   typedef enum logic [2:0] {
      ACT_IDLE    = 3'd0,
      ACT_CLEAR   = 3'd1,
      ACT_TEST    = 3'd2,
      ACT_RESTART = 3'd3,
      ACT_COUNT   = 3'd4
   } wdg_act_t;

   localparam int unsigned FRAMES_48K   = 4080;
   localparam int unsigned FRAMES_44K1  = 3749;
   localparam int unsigned FRAMES_32K   = 2720;

endpackage

// File: rtl/wdg_frame_sync.sv
module wdg_frame_sync #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RISE_EDGE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lr_async,
   output logic frame_evt
);

   localparam int unsigned TOP = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("wdg_frame_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], lr_async};
         last_q <= sync_q[TOP];
      end
   end

   generate
      if (RISE_EDGE) begin : g_rise
         assign frame_evt = sync_q[TOP] & ~last_q;
      end else begin : g_fall
         assign frame_evt = ~sync_q[TOP] & last_q;
      end
   endgenerate

endmodule

// File: rtl/wdg_period_reg.sv
module wdg_period_reg #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned PRESET   = 4080
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] value,
   output logic             accepted,
   output logic [CNT_W-1:0] period
);

   localparam logic [CNT_W-1:0] PRESET_V = CNT_W'(PRESET);

   assign accepted = load && (value != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period <= PRESET_V;
      end else if (accepted) begin
         period <= value;
      end
   end

endmodule

// File: rtl/wdg_phase_ctr.sv
module wdg_phase_ctr
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wdg_act_t         act,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             phase_end
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic last_frame;

   assign last_frame = (cnt >= (period - ONE));
   assign phase_end  = (act == ACT_COUNT) && last_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         unique case (act)
            ACT_CLEAR,
            ACT_TEST,
            ACT_RESTART: cnt <= '0;
            ACT_COUNT:   cnt <= last_frame ? '0 : cnt + ONE;
            default:     cnt <= cnt;
         endcase
      end
   end

endmodule

// File: rtl/wdg_pin_ctl.sv
module wdg_pin_ctl
   import wdg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  wdg_act_t act,
   input  logic     phase_end,
   output logic     pull_low
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pull_low <= 1'b0;
      end else begin
         unique case (act)
            ACT_CLEAR: pull_low <= 1'b0;
            ACT_TEST:  pull_low <= ~pull_low;
            ACT_COUNT: pull_low <= phase_end ? ~pull_low : pull_low;
            default:   pull_low <= pull_low;
         endcase
      end
   end

endmodule

// File: rtl/audio_wdog.sv
module audio_wdog
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned PRESET      = wdg_pkg::FRAMES_48K,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RISE_EDGE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lrclk_in,
   input  logic             run_en,
   input  logic             test_req,
   input  logic             soft_rst,
   input  logic             period_load,
   input  logic [CNT_W-1:0] period_value,
   output logic             wdc_pull_low
);

   generate
      if (PRESET == 0) begin : g_bad_preset
         $error("audio_wdog: PRESET must be nonzero");
      end
      if (PRESET >= (64'd1 << CNT_W)) begin : g_bad_width
         $error("audio_wdog: PRESET does not fit in CNT_W bits");
      end
   endgenerate

   logic             frame_evt;
   logic             load_ok;
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] cnt;
   logic             phase_end;
   wdg_act_t         act;

   wdg_frame_sync #(
      .SYNC_STAGES (SYNC_STAGES),
      .RISE_EDGE   (RISE_EDGE)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .lr_async  (lrclk_in),
      .frame_evt (frame_evt)
   );

   wdg_period_reg #(
      .CNT_W  (CNT_W),
      .PRESET (PRESET)
   ) u_period (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (period_load),
      .value    (period_value),
      .accepted (load_ok),
      .period   (period)
   );

   // Priority: soft reset / disable, test, reload, frame edge
   always_comb begin
      if (soft_rst || !run_en)  act = ACT_CLEAR;
      else if (test_req)        act = ACT_TEST;
      else if (load_ok)         act = ACT_RESTART;
      else if (frame_evt)       act = ACT_COUNT;
      else                      act = ACT_IDLE;
   end

   wdg_phase_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (act),
      .period    (period),
      .cnt       (cnt),
      .phase_end (phase_end)
   );

   wdg_pin_ctl u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (act),
      .phase_end (phase_end),
      .pull_low  (wdc_pull_low)
   );

endmodule

// File: rtl/audio_wdog_chk.sv
module audio_wdog_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             test_req,
   input logic             soft_rst,
   input logic             period_load,
   input logic [CNT_W-1:0] period_value,
   input logic             frame_evt,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] period,
   input logic             pin
);

   // R6
   soft_rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!pin && cnt == '0));

   // R5
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!pin && cnt == '0));

   // R7
   test_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !soft_rst && test_req) |=> (pin != $past(pin) && cnt == '0));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !soft_rst && !test_req && !frame_evt) |=> $stable(pin));

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < period);

   // R4
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (period_load && period_value != '0) |=> (period == $past(period_value)));

   // R4
   load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (period_load && period_value == '0) |=> $stable(period));

endmodule

bind audio_wdog audio_wdog_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .run_en       (run_en),
   .test_req     (test_req),
   .soft_rst     (soft_rst),
   .period_load  (period_load),
   .period_value (period_value),
   .frame_evt    (frame_evt),
   .cnt          (cnt),
   .period       (period),
   .pin          (wdc_pull_low)
);

// File: tb/audio_wdog_test.sv
module audio_wdog_test;

   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lrclk_in = 1'b0;
   logic             run_en = 1'b0;
   logic             test_req = 1'b0;
   logic             soft_rst = 1'b0;
   logic             period_load = 1'b0;
   logic [CNT_W-1:0] period_value = '0;
   logic             wdc_pull_low;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // frame-level reference state
   int  ex_n   = 4080;
   int  ex_cnt = 0;
   bit  ex_out = 0;

   always #2.5 clk = ~clk;

   audio_wdog uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .lrclk_in     (lrclk_in),
      .run_en       (run_en),
      .test_req     (test_req),
      .soft_rst     (soft_rst),
      .period_load  (period_load),
      .period_value (period_value),
      .wdc_pull_low (wdc_pull_low)
   );

   task automatic check(input string req, input logic exp);
      checks++;
      if (wdc_pull_low !== exp) begin
         errors++;
         $display("FAIL %s: wdc_pull_low=%0b expected %0b", req, wdc_pull_low, exp);
      end
   endtask

   function automatic bit next_out(input bit o, input int c, input int n);
      return (c + 1 >= n) ? ~o : o;
   endfunction

   function automatic int next_cnt(input int c, input int n);
      return (c + 1 >= n) ? 0 : c + 1;
   endfunction

   // one LR period; result is checked while LR is still high (R9 latency)
   task automatic frame(input int half, input string req);
      @(negedge clk) lrclk_in = 1'b1;
      if (run_en) begin
         ex_out = next_out(ex_out, ex_cnt, ex_n);
         ex_cnt = next_cnt(ex_cnt, ex_n);
      end
      repeat (half) @(negedge clk);
      check(req, ex_out);
      lrclk_in = 1'b0;
      repeat (half) @(negedge clk);
      check("R2 falling edge", ex_out);
   endtask

   task automatic pulse_test();
      @(negedge clk) test_req = 1'b1;
      @(negedge clk) test_req = 1'b0;
      if (run_en && !soft_rst) begin ex_out = ~ex_out; ex_cnt = 0; end
      check(run_en ? "R7 test toggle" : "R7 test ignored idle", ex_out);
   endtask

   task automatic pulse_soft();
      @(negedge clk) soft_rst = 1'b1;
      @(negedge clk) soft_rst = 1'b0;
      ex_out = 0; ex_cnt = 0;
      check("R6 soft reset", ex_out);
   endtask

   task automatic load(input int v);
      @(negedge clk) begin period_load = 1'b1; period_value = CNT_W'(v); end
      @(negedge clk) period_load = 1'b0;
      if (v != 0) begin ex_n = v; ex_cnt = 0; end
      check("R4 load", ex_out);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd7041));
      repeat (3) @(negedge clk);
      check("R1 reset release", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 1'b0);

      // R5: frames while disabled are ignored
      for (int i = 0; i < 3; i++) frame(4, "R5 disabled");
      pulse_test();

      // R3: default 4080-frame phase, first phase released (R2)
      run_en = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 4080; i++) frame(4, i == 4079 ? "R3 first toggle" : "R3 release phase");

      // R8: LR clock stopped, pin holds
      repeat (200) @(negedge clk);
      check("R8 stopped clock hold", ex_out);

      // R4: zero load ignored, then short periods
      load(0);
      for (int i = 0; i < 5; i++) frame(3, "R4 zero ignored");
      load(1);
      for (int i = 0; i < 4; i++) frame(3, "R2 period one");
      load(3);
      for (int i = 0; i < 7; i++) frame(5, "R2 period three");
      pulse_test();
      for (int i = 0; i < 4; i++) frame(3, "R7 restart count");
      pulse_soft();
      for (int i = 0; i < 4; i++) frame(3, "R6 after soft reset");

      // random mix
      for (int it = 0; it < 400; it++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 68) frame($urandom_range(3, 6), "R9 frame edge");
         else if (r < 76) pulse_test();
         else if (r < 82) pulse_soft();
         else if (r < 89) load($urandom_range(0, 6));
         else if (r < 95) begin
            @(negedge clk) run_en = ~run_en;
            @(negedge clk);
            if (!run_en) begin ex_out = 0; ex_cnt = 0; end
            check("R5 enable change", ex_out);
         end else begin
            repeat ($urandom_range(10, 40)) @(negedge clk);
            check("R8 idle hold", ex_out);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule